// File: doc/BRIEF.md
# 8-bit ALU with Staging Registers and Flags

This block is the arithmetic core of a small 8-bit processor. It holds an accumulator, a temporary accumulator and a temporary operand register. It also holds five condition flags. Operands are never taken straight from ports. A control sequence first stages them:

- the temporary register is filled from the internal bus;
- the accumulator is filled from the bus or from an earlier result;
- the temporary accumulator takes a copy of the accumulator.

An execute strobe then applies one of twelve operations to the two staged values and the carry flag.

Each operation result goes to one of two places. It is either written back into the accumulator or presented on an output bus for one cycle, as chosen by a destination bit. The flags update in the same clock edge. All state is registered, so every effect becomes visible one clock after the controlling inputs are sampled.

Top module: `alu8_core`

## Requirements
- R1: After reset (active-low `rst_n`) the accumulator, temporary accumulator, temporary register and all flags are 0, and `bus_oe` is 0.
- R2: On a clock edge, `ld_tmp` loads `bus_in` into the temporary register. `ld_acc` loads `bus_in` into the accumulator. `ld_act` copies the accumulator's value from before the edge into the temporary accumulator. If an executed operation writes the accumulator in the same cycle, its result takes priority over `ld_acc`.
- R3: Op 0 (add) gives act+tmp, and op 1 (add with carry) gives act+tmp+carry flag. The result is the low 8 bits, and the carry flag takes the carry out of bit 7.
- R4: Op 2 (subtract) gives act-tmp, and op 3 (subtract with borrow) gives act-tmp-carry flag. The result is the low 8 bits, and the carry flag is set when a borrow occurs (the true difference is negative).
- R5: For ops 0 to 3 and op 7, auxiliary carry is the carry out of bit 3 of act + operand + carry-in. For add, the operand is tmp and the carry-in is the carry used. For subtract and compare, the operand is the bitwise inverse of tmp and the carry-in is the inverse of the borrow used.
- R6: For ops 0 to 7, zero is set when the result is 0, sign equals result bit 7, and parity is set when the result has an even number of one bits.
- R7: Ops 4 (AND), 5 (XOR) and 6 (OR) combine act and tmp bitwise and clear both carry and auxiliary carry.
- R8: Op 7 (compare) sets every flag exactly as op 2 would and writes no result to either the accumulator or the bus.
- R9: Ops 8 to 11 rotate act. Op 8 rotates left, with bit 7 going into bit 0 and the carry. Op 9 rotates right, with bit 0 going into bit 7 and the carry. Op 10 rotates left through the carry. Op 11 rotates right through the carry. Only the carry flag changes.
- R10: With `dst_bus`=1, a result-writing op puts its result on `bus_out` with `bus_oe`=1 for exactly the next cycle and leaves the accumulator alone. With `dst_bus`=0 the result is written into the accumulator and `bus_oe` stays 0.
- R11: Op codes 12 to 15 under `exec` change no flag, no register and no output.
- R12: The `flags` port packs the flags as bit0 carry, bit1 parity, bit2 auxiliary carry, bit3 zero and bit4 sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Internal bus value for register loads |
| ld_tmp | input | 1 | Load temporary register from bus_in |
| ld_acc | input | 1 | Load accumulator from bus_in |
| ld_act | input | 1 | Copy accumulator into temporary accumulator |
| exec | input | 1 | Perform the operation selected by op |
| op | input | 4 | Operation select (0 to 11 valid) |
| dst_bus | input | 1 | 1: result to bus_out, 0: result to accumulator |
| acc | output | 8 | Accumulator contents |
| flags | output | 5 | Flag register {sign, zero, aux, parity, carry} |
| bus_out | output | 8 | Result presented toward the bus |
| bus_oe | output | 1 | bus_out carries a fresh result this cycle |

## Verification
The hardest cases to reach combine a borrow-in subtract or a compare with operands sitting on a nibble or byte boundary. Operands are staged through three registers and a flag set by an earlier operation, so reaching them takes a sequence of earlier operations. The directed part of the stimulus builds that sequence deliberately: it loads the bus, copies into the temporary accumulator, and primes the carry with a preceding operation. Only then does it issue the subtract with borrow or the compare. A long random phase follows. It fires the load strobes together with execute, so accumulator-copy and write-back collisions happen often. Every clock is checked against a behavioural model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_XOR = 4'd5,
        OP_OR  = 4'd6,
        OP_CMP = 4'd7,
        OP_RLC = 4'd8,
        OP_RRC = 4'd9,
        OP_RAL = 4'd10,
        OP_RAR = 4'd11,
        OP_N12 = 4'd12,
        OP_N13 = 4'd13,
        OP_N14 = 4'd14,
        OP_N15 = 4'd15
    } op_e;

    typedef struct packed {
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } flags_t;

    function automatic logic op_valid(input op_e op);
        return op <= OP_RAR;
    endfunction

    function automatic logic op_writes(input op_e op);
        return (op <= OP_RAR) && (op != OP_CMP);
    endfunction

    function automatic logic op_rotate(input op_e op);
        return (op >= OP_RLC) && (op <= OP_RAR);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  op_e          op_i,
    output logic [W-1:0] res_o,
    output logic         cy_o,
    output logic         ac_o
);
    localparam int NIB = W / 2;

    logic         sub_sel;
    logic         use_c;
    logic         ci;
    logic [W-1:0] b_eff;
    logic [W:0]   sum;
    logic [NIB:0] lo_sum;

    always_comb begin
        sub_sel = (op_i == OP_SUB) || (op_i == OP_SBB) || (op_i == OP_CMP);
        use_c   = (op_i == OP_ADC) || (op_i == OP_SBB);
        b_eff   = sub_sel ? ~b_i : b_i;
        ci      = sub_sel ? ~(use_c & cin_i) : (use_c & cin_i);
        sum     = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, ci};
        lo_sum  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, ci};

        res_o = a_i;
        cy_o  = 1'b0;
        ac_o  = 1'b0;
        case (op_i)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
                res_o = sum[W-1:0];
                cy_o  = sub_sel ? ~sum[W] : sum[W];
                ac_o  = lo_sum[NIB];
            end
            OP_AND: res_o = a_i & b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_RLC: begin
                res_o = {a_i[W-2:0], a_i[W-1]};
                cy_o  = a_i[W-1];
            end
            OP_RRC: begin
                res_o = {a_i[0], a_i[W-1:1]};
                cy_o  = a_i[0];
            end
            OP_RAL: begin
                res_o = {a_i[W-2:0], cin_i};
                cy_o  = a_i[W-1];
            end
            OP_RAR: begin
                res_o = {cin_i, a_i[W-1:1]};
                cy_o  = a_i[0];
            end
            default: begin
                res_o = a_i;
                cy_o  = 1'b0;
                ac_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] res_i,
    input  logic         cy_i,
    input  logic         ac_i,
    input  op_e          op_i,
    input  flags_t       old_i,
    output flags_t       new_o
);
    always_comb begin
        if (!op_valid(op_i)) begin
            new_o = old_i;
        end else if (op_rotate(op_i)) begin
            new_o     = old_i;
            new_o.cry = cy_i;
        end else begin
            new_o.sgn = res_i[W-1];
            new_o.zro = (res_i == '0);
            new_o.aux = ac_i;
            new_o.par = ~^res_i;
            new_o.cry = cy_i;
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_in,
    input  logic         ld_tmp,
    input  logic         ld_acc,
    input  logic         ld_act,
    input  logic         exec,
    input  logic [3:0]   op,
    input  logic         dst_bus,
    output logic [W-1:0] acc,
    output logic [4:0]   flags,
    output logic [W-1:0] bus_out,
    output logic         bus_oe
);
    localparam int FW = $bits(flags_t);

    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] act;
        logic [W-1:0] tmp;
        flags_t       flg;
        logic [W-1:0] bus;
        logic         oe;
    } st_t;

    st_t    st_d, st_q;
    op_e    op_sel;
    logic [W-1:0] alu_res;
    logic   alu_cy, alu_ac;
    flags_t flg_next;

    assign op_sel = op_e'(op);

    alu8_arith #(.W(W)) u_arith (
        .a_i   (st_q.act),
        .b_i   (st_q.tmp),
        .cin_i (st_q.flg.cry),
        .op_i  (op_sel),
        .res_o (alu_res),
        .cy_o  (alu_cy),
        .ac_o  (alu_ac)
    );

    alu8_flags #(.W(W)) u_flags (
        .res_i (alu_res),
        .cy_i  (alu_cy),
        .ac_i  (alu_ac),
        .op_i  (op_sel),
        .old_i (st_q.flg),
        .new_o (flg_next)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oe = 1'b0;
        if (ld_tmp) st_d.tmp = bus_in;
        if (ld_act) st_d.act = st_q.acc;
        if (ld_acc) st_d.acc = bus_in;
        if (exec) begin
            st_d.flg = flg_next;
            if (op_writes(op_sel)) begin
                if (dst_bus) begin
                    st_d.bus = alu_res;
                    st_d.oe  = 1'b1;
                end else begin
                    st_d.acc = alu_res;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc     = st_q.acc;
    assign flags   = st_q.flg[FW-1:0];
    assign bus_out = st_q.bus;
    assign bus_oe  = st_q.oe;

    // R7: logic ops leave carry and aux carry cleared
    a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (op == 4'd4 || op == 4'd5 || op == 4'd6)) |=> (!flags[0] && !flags[2]));

    // R9: rotates keep all flags except carry
    a_r9_rot_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op >= 4'd8 && op <= 4'd11) |=> (flags[4:1] == $past(flags[4:1])));

    // R11: reserved codes change no flag
    a_r11_nop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op >= 4'd12) |=> $stable(flags));

    // R8: compare writes no accumulator value
    a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == 4'd7 && !ld_acc) |=> $stable(acc));

    // R10: bus result never disturbs the accumulator
    a_r10_bus_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && dst_bus && !ld_acc) |=> $stable(acc));

    // R10: output enable only follows a bus-directed result-writing op
    a_r10_oe_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(exec && dst_bus && op <= 4'd11 && op != 4'd7));

endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_in = '0;
    logic       ld_tmp = 1'b0, ld_acc = 1'b0, ld_act = 1'b0;
    logic       exec = 1'b0, dst_bus = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] acc, bus_out;
    logic [4:0] flags;
    logic       bus_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // behavioural reference state
    int m_acc, m_act, m_tmp, m_bus, m_oe;
    int m_cy, m_par, m_ac, m_z, m_s;

    always #(CLK_NS/2) clk = ~clk;

    alu8_core dut_i (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
        .ld_tmp(ld_tmp), .ld_acc(ld_acc), .ld_act(ld_act),
        .exec(exec), .op(op), .dst_bus(dst_bus),
        .acc(acc), .flags(flags), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    task automatic check(input string req, input int act_v, input int exp_v, input string what);
        n_checks++;
        if (act_v != exp_v) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    function automatic string tag_for(input int o, input int ex);
        if (!ex) return "R2";
        if (o <= 1) return "R3";
        if (o <= 3) return "R4";
        if (o <= 6) return "R7";
        if (o == 7) return "R8";
        if (o <= 11) return "R9";
        return "R11";
    endfunction

    // model update for one clock edge
    task automatic model_step(input int bi, input int lt, input int la, input int lc,
                              input int ex, input int o, input int db);
        int a, b, c, r, cy, ac, t, ones;
        int n_acc, n_act, n_tmp;
        a = m_act; b = m_tmp; c = m_cy;
        n_acc = m_acc; n_act = m_act; n_tmp = m_tmp;
        if (lt) n_tmp = bi;
        if (lc) n_act = m_acc;
        if (la) n_acc = bi;
        m_oe = 0;
        if (ex && o <= 11) begin
            cy = 0; ac = 0; r = a;
            case (o)
                0, 1: begin
                    t  = (o == 1) ? c : 0;
                    r  = a + b + t;
                    cy = (r > 255) ? 1 : 0;
                    ac = (((a % 16) + (b % 16) + t) > 15) ? 1 : 0;
                end
                2, 3, 7: begin
                    t  = (o == 3) ? c : 0;
                    r  = a - b - t;
                    cy = (r < 0) ? 1 : 0;
                    ac = (((a % 16) + (15 - (b % 16)) + (1 - t)) > 15) ? 1 : 0;
                end
                4: r = a & b;
                5: r = a ^ b;
                6: r = a | b;
                8: begin cy = a / 128; r = (a * 2) % 256 + a / 128; end
                9: begin cy = a % 2;   r = a / 2 + (a % 2) * 128; end
                10: begin cy = a / 128; r = (a * 2) % 256 + c; end
                default: begin cy = a % 2; r = a / 2 + c * 128; end
            endcase
            r = ((r % 256) + 256) % 256;
            m_cy = cy;
            if (o < 8) begin
                ones = 0;
                for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
                m_ac  = ac;
                m_z   = (r == 0) ? 1 : 0;
                m_s   = r / 128;
                m_par = (ones % 2 == 0) ? 1 : 0;
            end
            if (o != 7) begin
                if (db) begin m_bus = r; m_oe = 1; end
                else n_acc = r;
            end
        end
        m_acc = n_acc; m_act = n_act; m_tmp = n_tmp;
    endtask

    function automatic int m_flags();
        return m_s * 16 + m_z * 8 + m_ac * 4 + m_par * 2 + m_cy;
    endfunction

    task automatic compare_all(input string req);
        check(req, acc, m_acc, "acc");
        check(req, flags, m_flags(), "flags (R12 packing)");
        check("R10", bus_oe, m_oe, "bus_oe");
        if (m_oe) check("R10", bus_out, m_bus, "bus_out");
    endtask

    // one clock: drive just after a falling edge, compare at the next falling edge
    task automatic cyc(input int bi, input int lt, input int la, input int lc,
                       input int ex, input int o, input int db);
        bus_in = bi[7:0]; ld_tmp = lt[0]; ld_acc = la[0]; ld_act = lc[0];
        exec = ex[0]; op = o[3:0]; dst_bus = db[0];
        @(posedge clk);
        model_step(bi, lt, la, lc, ex, o, db);
        @(negedge clk);
        compare_all(tag_for(o, ex));
    endtask

    // stage act=a, tmp=b, then execute op
    task automatic run_op(input int a, input int b, input int o, input int db);
        cyc(a, 0, 1, 0, 0, 0, 0);
        cyc(b, 1, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, o, db);
    endtask

    initial begin
        m_acc = 0; m_act = 0; m_tmp = 0; m_bus = 0; m_oe = 0;
        m_cy = 0; m_par = 0; m_ac = 0; m_z = 0; m_s = 0;
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R2: loads and priority
        cyc(8'h5A, 1, 1, 1, 0, 0, 0);
        cyc(8'h33, 0, 0, 1, 0, 0, 0);
        cyc(8'h99, 0, 1, 0, 1, 0, 0);      // exec write beats ld_acc
        // R3 / R5 boundaries
        run_op(8'h0F, 8'h01, 0, 0);         // aux carry
        run_op(8'hFF, 8'h01, 0, 0);         // zero + carry
        run_op(8'h80, 8'h80, 1, 0);         // adc with carry in
        // R4 / R5 / R8
        run_op(8'h10, 8'h01, 2, 0);
        run_op(8'h00, 8'h01, 3, 0);         // borrow out, sets carry
        cyc(8'h00, 0, 0, 0, 1, 3, 0);       // sbb with borrow in
        run_op(8'h42, 8'h42, 7, 0);         // compare equal
        run_op(8'h01, 8'h02, 7, 1);         // compare, bus dest: no drive
        // R7 logic
        run_op(8'hF0, 8'h3C, 4, 0);
        run_op(8'hF0, 8'h3C, 5, 1);
        run_op(8'hF0, 8'h0F, 6, 0);
        // R9 rotates
        for (int o = 8; o <= 11; o++) begin
            run_op(8'h81, 8'h00, o, 0);
            run_op(8'h40, 8'h00, o, 1);
        end
        // R11 reserved codes
        for (int o = 12; o <= 15; o++) run_op(8'hA5, 8'h5A, o, o % 2);
        // R6 parity / sign sweep
        for (int v = 0; v < 256; v += 17) run_op(v, 8'h00, 0, 0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom;
            cyc(int'($urandom % 256), r & 1, (r >> 1) & 1, (r >> 2) & 1,
                ((r >> 3) & 3) != 0, (r >> 5) % 16, (r >> 9) & 1);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule